// File: doc/BRIEF.md
# CAN Mailbox Transmit Request Controller

This block keeps the software-visible transmit bookkeeping for three CAN transmit mailboxes. Software queues a frame by writing 1 to a mailbox bit of the pending register. It asks for a queued frame to be withdrawn through the cancel register. It acknowledges finished work by clearing the transmit-done and abort-done flags. The CAN protocol engine sits on the other side and sees the pending and cancel bits as per-mailbox levels. It answers with single-cycle pulses: `tx_done` means the frame went out, and `cancel_ok` means the withdrawal was accepted. A `bus_busy` level marks the mailbox whose frame is on the wire at that moment.

The byte-wide register window has five locations. Address 0 is pending, 1 is cancel, 2 is transmit-done, 3 is abort-done and 4 is interrupt enable. Mailbox k (k = 0..2 on the controller-side vectors) sits on register bit k+1. Bit 0 belongs to a receive-only mailbox. Bits 0 and 7..4 of every location read 0 and cannot be written. Reads are combinational from `reg_addr`, and unused addresses read 0.

Top module: `can_txreq_ctrl`

## Requirements
- R1: Only register bits 3..1 hold state, and they map to mailboxes 0..2. Writing 0xFF to the pending register reads back 0x0E and drives `pend_o` to 3'b111.
- R2: Bits 7..4 and bit 0 of every register read as 0 whatever was written.
- R3: A 1 written to a cancel bit is stored only if the matching pending bit is already 1. Otherwise it is dropped, and a stored cancel bit is never 1 while its pending bit is 0.
- R4: Writing 0 to a cancel bit leaves it unchanged.
- R5: On a `cancel_ok` pulse for a mailbox whose cancel bit is 1, whose `bus_busy` is 0 and whose `tx_done` is 0, the pending and cancel bits clear together on the next clock. The abort-done bit sets on that same clock.
- R6: A `tx_done` pulse for a pending mailbox sets its transmit-done bit and clears its pending bit. A `tx_done` pulse for a mailbox that is not pending changes nothing.
- R7: Writing 1 to a transmit-done bit clears it. Writing 0 leaves it unchanged.
- R8: After reset, all five registers read 0 and `irq` is 0.
- R9: While `bus_busy` is 1, `cancel_ok` is ignored and the cancel request stays held. If that transmission then completes, pending and cancel clear, transmit-done sets and abort-done stays 0.
- R10: Abort-done bits are write-1-to-clear. If a hardware set and a software clear hit the same bit in one cycle, the bit ends up 1.
- R11: Writing 0 to a pending bit leaves it unchanged. Pending clears only on completion or on an accepted cancel.
- R12: `irq` is 1 exactly while some mailbox has its enable bit (address 4) set together with its transmit-done or abort-done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tx_done | input | 3 | Per-mailbox pulse: frame sent successfully |
| cancel_ok | input | 3 | Per-mailbox pulse: cancellation accepted by the engine |
| bus_busy | input | 3 | Per-mailbox level: frame currently on the bus |
| pend_o | output | 3 | Pending request levels to the engine |
| cancel_o | output | 3 | Cancel request levels to the engine |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `tx_done` and `cancel_ok` are single-cycle pulses. It also assumes the engine asserts `bus_busy` only for a mailbox that is pending. Under those conditions, a held cancel, a completion and an accepted cancel each have a single outcome. The directed tests drive each pulse for exactly one clock. They raise `bus_busy` only on a mailbox queued just before, and they drop it again before the next scenario. The one deliberate collision, an abort-done set and clear in the same cycle, is issued as a single combined cycle so that the set-wins rule is the only thing under test.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;

    localparam int TXQ_NUM_MB  = 3;
    localparam int TXQ_MB_LSB  = 1;
    localparam int TXQ_DATA_W  = 8;
    localparam int TXQ_ADDR_W  = 3;

    typedef enum logic [2:0] {
        SEL_PEND  = 3'd0,
        SEL_CANC  = 3'd1,
        SEL_TXACK = 3'd2,
        SEL_ABORT = 3'd3,
        SEL_IEN   = 3'd4
    } reg_sel_e;

    // state of one transmit mailbox
    typedef struct packed {
        logic pend;
        logic canc;
        logic txack;
        logic abort;
    } slot_state_t;

    // software requests reaching one mailbox in a cycle
    typedef struct packed {
        logic set_pend;
        logic set_canc;
        logic clr_txack;
        logic clr_abort;
    } slot_cmd_t;

    // engine events reaching one mailbox in a cycle
    typedef struct packed {
        logic done;
        logic cok;
        logic busy;
    } slot_evt_t;

    function automatic slot_state_t slot_next(slot_state_t cur, slot_cmd_t cmd,
                                              slot_evt_t evt);
        slot_state_t nx;
        logic done_hit;
        logic canc_hit;
        done_hit = evt.done & cur.pend;
        canc_hit = cur.canc & evt.cok & ~evt.busy & ~done_hit;
        nx.pend  = (cur.pend & ~(done_hit | canc_hit)) | cmd.set_pend;
        nx.canc  = (cur.canc | (cmd.set_canc & cur.pend)) & ~(done_hit | canc_hit);
        nx.txack = (cur.txack & ~cmd.clr_txack) | done_hit;
        nx.abort = (cur.abort & ~cmd.clr_abort) | canc_hit;
        return nx;
    endfunction

endpackage

// File: rtl/can_txreq_regif.sv
module can_txreq_regif
    import can_txreq_pkg::*;
#(
    parameter int NUM_MB = TXQ_NUM_MB,
    parameter int MB_LSB = TXQ_MB_LSB,
    parameter int DATA_W = TXQ_DATA_W,
    parameter int ADDR_W = TXQ_ADDR_W
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [NUM_MB-1:0] set_pend,
    output logic [NUM_MB-1:0] set_canc,
    output logic [NUM_MB-1:0] clr_txack,
    output logic [NUM_MB-1:0] clr_abort,
    output logic              ien_we,
    output logic [NUM_MB-1:0] ien_wval,
    input  logic [NUM_MB-1:0] pend_v,
    input  logic [NUM_MB-1:0] canc_v,
    input  logic [NUM_MB-1:0] txack_v,
    input  logic [NUM_MB-1:0] abort_v,
    input  logic [NUM_MB-1:0] ien_v,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [NUM_MB-1:0] wslice;
    logic [NUM_MB-1:0] rsel;
    logic              hit_pend, hit_canc, hit_txack, hit_abort, hit_ien;

    assign wslice    = reg_wdata[MB_LSB +: NUM_MB];
    assign hit_pend  = (reg_addr == ADDR_W'(SEL_PEND));
    assign hit_canc  = (reg_addr == ADDR_W'(SEL_CANC));
    assign hit_txack = (reg_addr == ADDR_W'(SEL_TXACK));
    assign hit_abort = (reg_addr == ADDR_W'(SEL_ABORT));
    assign hit_ien   = (reg_addr == ADDR_W'(SEL_IEN));

    assign set_pend  = wslice & {NUM_MB{reg_wr & hit_pend}};
    assign set_canc  = wslice & {NUM_MB{reg_wr & hit_canc}};
    assign clr_txack = wslice & {NUM_MB{reg_wr & hit_txack}};
    assign clr_abort = wslice & {NUM_MB{reg_wr & hit_abort}};
    assign ien_we    = reg_wr & hit_ien;
    assign ien_wval  = wslice;

    always_comb begin
        rsel = '0;
        if (hit_pend)  rsel = pend_v;
        if (hit_canc)  rsel = canc_v;
        if (hit_txack) rsel = txack_v;
        if (hit_abort) rsel = abort_v;
        if (hit_ien)   rsel = ien_v;
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[MB_LSB +: NUM_MB] = rsel;
    end

endmodule

// File: rtl/can_txreq_slot.sv
module can_txreq_slot
    import can_txreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slot_cmd_t   cmd,
    input  slot_evt_t   evt,
    output slot_state_t st
);

    slot_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= slot_next(st_q, cmd, evt);
        end
    end

    assign st = st_q;

endmodule

// File: rtl/can_txreq_irq.sv
module can_txreq_irq #(
    parameter int NUM_MB = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ien_we,
    input  logic [NUM_MB-1:0] ien_wval,
    input  logic [NUM_MB-1:0] txack_v,
    input  logic [NUM_MB-1:0] abort_v,
    output logic [NUM_MB-1:0] ien_v,
    output logic              irq
);

    logic [NUM_MB-1:0] ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (ien_we) begin
            ien_q <= ien_wval;
        end
    end

    assign ien_v = ien_q;
    assign irq   = |((txack_v | abort_v) & ien_q);

endmodule

// File: rtl/can_txreq_ctrl.sv
module can_txreq_ctrl
    import can_txreq_pkg::*;
#(
    parameter int NUM_MB = TXQ_NUM_MB,
    parameter int MB_LSB = TXQ_MB_LSB,
    parameter int DATA_W = TXQ_DATA_W,
    parameter int ADDR_W = TXQ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_MB-1:0] tx_done,
    input  logic [NUM_MB-1:0] cancel_ok,
    input  logic [NUM_MB-1:0] bus_busy,
    output logic [NUM_MB-1:0] pend_o,
    output logic [NUM_MB-1:0] cancel_o,
    output logic              irq
);

    logic [NUM_MB-1:0] set_pend, set_canc, clr_txack, clr_abort;
    logic              ien_we;
    logic [NUM_MB-1:0] ien_wval, ien_v;
    logic [NUM_MB-1:0] pend_q, canc_q, txack_q, abort_q;

    can_txreq_regif #(
        .NUM_MB(NUM_MB), .MB_LSB(MB_LSB), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .set_pend  (set_pend),
        .set_canc  (set_canc),
        .clr_txack (clr_txack),
        .clr_abort (clr_abort),
        .ien_we    (ien_we),
        .ien_wval  (ien_wval),
        .pend_v    (pend_q),
        .canc_v    (canc_q),
        .txack_v   (txack_q),
        .abort_v   (abort_q),
        .ien_v     (ien_v),
        .reg_rdata (reg_rdata)
    );

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        slot_cmd_t   cmd;
        slot_evt_t   evt;
        slot_state_t st;

        assign cmd.set_pend  = set_pend[g];
        assign cmd.set_canc  = set_canc[g];
        assign cmd.clr_txack = clr_txack[g];
        assign cmd.clr_abort = clr_abort[g];
        assign evt.done      = tx_done[g];
        assign evt.cok       = cancel_ok[g];
        assign evt.busy      = bus_busy[g];

        can_txreq_slot u_slot (
            .clk (clk),
            .rst (rst),
            .cmd (cmd),
            .evt (evt),
            .st  (st)
        );

        assign pend_q[g]  = st.pend;
        assign canc_q[g]  = st.canc;
        assign txack_q[g] = st.txack;
        assign abort_q[g] = st.abort;
    end

    can_txreq_irq #(.NUM_MB(NUM_MB)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .ien_we   (ien_we),
        .ien_wval (ien_wval),
        .txack_v  (txack_q),
        .abort_v  (abort_q),
        .ien_v    (ien_v),
        .irq      (irq)
    );

    assign pend_o   = pend_q;
    assign cancel_o = canc_q;

endmodule

// File: rtl/can_txreq_chk.sv
module can_txreq_chk #(
    parameter int NUM_MB = 3,
    parameter int MB_LSB = 1,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_MB-1:0] tx_done,
    input logic [NUM_MB-1:0] cancel_ok,
    input logic [NUM_MB-1:0] bus_busy,
    input logic [NUM_MB-1:0] pend_o,
    input logic [NUM_MB-1:0] cancel_o,
    input logic [NUM_MB-1:0] txack_q,
    input logic [NUM_MB-1:0] abort_q,
    input logic              irq
);

    localparam logic [DATA_W-1:0] LIVE_MASK = ((DATA_W'(1) << NUM_MB) - DATA_W'(1)) << MB_LSB;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_MASK) == '0);

    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((txack_q | abort_q) != '0));

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        assert_cancel_needs_pend_R3: assert property (@(posedge clk) disable iff (rst)
            cancel_o[i] |-> pend_o[i]);

        assert_cancel_done_R5: assert property (@(posedge clk) disable iff (rst)
            (cancel_o[i] && cancel_ok[i] && !bus_busy[i] && !tx_done[i])
            |=> (abort_q[i] && !cancel_o[i]));

        assert_done_sets_ack_R6: assert property (@(posedge clk) disable iff (rst)
            (tx_done[i] && pend_o[i]) |=> txack_q[i]);

        assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
            (cancel_o[i] && bus_busy[i] && !tx_done[i]) |=> cancel_o[i]);

        assert_abort_source_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(abort_q[i]) |-> $past(cancel_o[i]));
    end

endmodule

bind can_txreq_ctrl can_txreq_chk #(
    .NUM_MB(NUM_MB), .MB_LSB(MB_LSB), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .tx_done   (tx_done),
    .cancel_ok (cancel_ok),
    .bus_busy  (bus_busy),
    .pend_o    (pend_o),
    .cancel_o  (cancel_o),
    .txack_q   (txack_q),
    .abort_q   (abort_q),
    .irq       (irq)
);

// File: tb/can_txreq_ctrl_bench.sv
module can_txreq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [2:0] tx_done = 3'd0;
    logic [2:0] cancel_ok = 3'd0;
    logic [2:0] bus_busy = 3'd0;
    logic [2:0] pend_o;
    logic [2:0] cancel_o;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit over = 1'b0;

    localparam logic [2:0] A_PEND = 3'd0, A_CANC = 3'd1, A_TXACK = 3'd2,
                           A_ABORT = 3'd3, A_IEN = 3'd4;

    always #4 clk = ~clk;

    can_txreq_ctrl u_can_txreq_ctrl (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .tx_done (tx_done),
        .cancel_ok (cancel_ok), .bus_busy (bus_busy), .pend_o (pend_o),
        .cancel_o (cancel_o), .irq (irq)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    // one clock with optional write and engine events, then back to idle
    task automatic cyc(bit wr, logic [2:0] a, logic [7:0] d,
                       logic [2:0] dn, logic [2:0] ok);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tx_done = dn; cancel_ok = ok;
        @(negedge clk);
        reg_wr = 1'b0; tx_done = 3'd0; cancel_ok = 3'd0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cyc(1'b1, a, d, 3'd0, 3'd0);
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_busy = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R8", "reset value", v, 8'h00);
        end
        check("R8", "irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        do_reset();
        wr(A_PEND, 8'hFF);
        rd(A_PEND, v);
        check("R1", "pending after 0xFF", v, 8'h0E);
        check("R1", "pend_o", {5'd0, pend_o}, 8'h07);
        wr(A_CANC, 8'hF1);
        rd(A_CANC, v);
        check("R2", "cancel reserved bits", v, 8'h00);
        wr(A_IEN, 8'hFF);
        rd(A_IEN, v);
        check("R2", "enable reserved bits", v, 8'h0E);
    endtask

    task automatic t_cancel_gate();
        logic [7:0] v;
        do_reset();
        wr(A_CANC, 8'h04);
        rd(A_CANC, v);
        check("R3", "cancel without pending", v, 8'h00);
        wr(A_PEND, 8'h04);
        wr(A_CANC, 8'h00);
        rd(A_CANC, v);
        check("R4", "cancel write 0", v, 8'h00);
        wr(A_CANC, 8'h04);
        rd(A_CANC, v);
        check("R3", "cancel with pending", v, 8'h04);
        wr(A_CANC, 8'h00);
        rd(A_CANC, v);
        check("R4", "cancel write 0 keeps set bit", v, 8'h04);
    endtask

    task automatic t_cancel_ok();
        logic [7:0] v;
        // continues from t_cancel_gate: mailbox 1 pending and cancel requested
        cyc(1'b0, A_PEND, 8'h00, 3'd0, 3'b010);
        rd(A_PEND, v);
        check("R5", "pending after cancel", v, 8'h00);
        rd(A_CANC, v);
        check("R5", "cancel after cancel", v, 8'h00);
        rd(A_ABORT, v);
        check("R5", "abort-done after cancel", v, 8'h04);
        rd(A_TXACK, v);
        check("R5", "transmit-done after cancel", v, 8'h00);
    endtask

    task automatic t_txdone();
        logic [7:0] v;
        do_reset();
        cyc(1'b0, A_PEND, 8'h00, 3'b001, 3'd0);
        rd(A_TXACK, v);
        check("R6", "done on idle mailbox", v, 8'h00);
        wr(A_PEND, 8'h02);
        cyc(1'b0, A_PEND, 8'h00, 3'b001, 3'd0);
        rd(A_TXACK, v);
        check("R6", "transmit-done set", v, 8'h02);
        rd(A_PEND, v);
        check("R6", "pending cleared", v, 8'h00);
        wr(A_TXACK, 8'h00);
        rd(A_TXACK, v);
        check("R7", "write 0 keeps flag", v, 8'h02);
        wr(A_TXACK, 8'h02);
        rd(A_TXACK, v);
        check("R7", "write 1 clears flag", v, 8'h00);
    endtask

    task automatic t_busy_cancel();
        logic [7:0] v;
        do_reset();
        wr(A_PEND, 8'h08);
        wr(A_CANC, 8'h08);
        bus_busy = 3'b100;
        cyc(1'b0, A_PEND, 8'h00, 3'd0, 3'b100);
        rd(A_CANC, v);
        check("R9", "cancel held while busy", v, 8'h08);
        rd(A_PEND, v);
        check("R9", "pending held while busy", v, 8'h08);
        cyc(1'b0, A_PEND, 8'h00, 3'b100, 3'd0);
        bus_busy = 3'd0;
        rd(A_PEND, v);
        check("R9", "pending after completion", v, 8'h00);
        rd(A_CANC, v);
        check("R9", "cancel after completion", v, 8'h00);
        rd(A_TXACK, v);
        check("R9", "transmit-done after completion", v, 8'h08);
        rd(A_ABORT, v);
        check("R9", "abort-done stays 0", v, 8'h00);
    endtask

    task automatic t_abort_w1c();
        logic [7:0] v;
        do_reset();
        wr(A_PEND, 8'h02);
        wr(A_CANC, 8'h02);
        cyc(1'b0, A_PEND, 8'h00, 3'd0, 3'b001);
        wr(A_PEND, 8'h02);
        wr(A_CANC, 8'h02);
        // clear and a fresh set in the same cycle
        cyc(1'b1, A_ABORT, 8'h02, 3'd0, 3'b001);
        rd(A_ABORT, v);
        check("R10", "set beats clear", v, 8'h02);
        wr(A_ABORT, 8'h00);
        rd(A_ABORT, v);
        check("R10", "write 0 keeps abort-done", v, 8'h02);
        wr(A_ABORT, 8'h02);
        rd(A_ABORT, v);
        check("R10", "write 1 clears abort-done", v, 8'h00);
    endtask

    task automatic t_pend_w0();
        logic [7:0] v;
        do_reset();
        wr(A_PEND, 8'h06);
        wr(A_PEND, 8'h00);
        rd(A_PEND, v);
        check("R11", "write 0 keeps pending", v, 8'h06);
        wr(A_PEND, 8'h08);
        rd(A_PEND, v);
        check("R11", "set adds to pending", v, 8'h0E);
    endtask

    task automatic t_irq();
        do_reset();
        wr(A_PEND, 8'h02);
        cyc(1'b0, A_PEND, 8'h00, 3'b001, 3'd0);
        check("R12", "irq with enable off", {7'd0, irq}, 8'h00);
        wr(A_IEN, 8'h04);
        check("R12", "irq with other enable", {7'd0, irq}, 8'h00);
        wr(A_IEN, 8'h02);
        check("R12", "irq enabled", {7'd0, irq}, 8'h01);
        wr(A_TXACK, 8'h02);
        check("R12", "irq after clear", {7'd0, irq}, 8'h00);
        wr(A_PEND, 8'h02);
        wr(A_CANC, 8'h02);
        cyc(1'b0, A_PEND, 8'h00, 3'd0, 3'b001);
        check("R12", "irq from abort-done", {7'd0, irq}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_cancel_gate();
        t_cancel_ok();
        t_txdone();
        t_busy_cancel();
        t_abort_w1c();
        t_pend_w0();
        t_irq();
        if (!over) begin
            over = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule